// File: doc/BRIEF.md
# Block Transfer Micro-op Sequencer

This block turns one block transfer command into a run of memory beats. Each beat moves one 64-bit register of a consecutive register group. Both block loads and block stores are supported. The command arrives on a valid/ready channel. It carries a load/store select and two base operands. A mode bit picks the second operand: the second base register, or a sign-extended 13-bit immediate. The command also carries the first register index of the group, the current privilege level, and a flag that marks the access space as privileged-only. The sequencer computes the effective address once. It checks that address for faults, then issues eight requests on a valid/ready request channel. Beat n uses address EA + 8·n and register index rd + n.

Fault checks apply to the first beat only. Two faults are checked: a privileged-space access made without privilege, and a block address that is not aligned to the 64-byte block. When both apply, the alignment fault wins. A faulting command issues no request and reports a one-cycle fault pulse. Each beat carries three tags: first, last and delayed-commit. Downstream logic uses these tags to retire the group as one unit.

Back-pressure works as follows. The block accepts a command only while it is idle (`cmd_ready` high). A request, once valid, holds its address, register index, direction and tags until `req_ready` is seen high at a clock edge. Only then does the next beat appear.

Top module: `blkmem_seq`

## Requirements
- R1: `cmd_ready` is high exactly when no beat is outstanding. `cmd_ready` and `req_valid` are never both high. A command accepted in cycle t shows either `req_valid` or `fault_valid` in cycle t+1, never both.
- R2: In register form (`cmd_use_imm`=0), beat n has `req_addr` = `cmd_base_a` + `cmd_base_b` + 8·n, wrapping modulo 2^ADDR_W.
- R3: In immediate form (`cmd_use_imm`=1), beat n has `req_addr` = `cmd_base_a` + sign-extended `cmd_imm` + 8·n. Negative immediates are allowed, and `cmd_base_b` has no effect in this form.
- R4: Beat n has `req_reg` = `cmd_rd` + n modulo 2^REG_W. `req_store` equals the command's `cmd_store` on every beat.
- R5: Beat 0 has `req_first`=1. Beats 0 to 6 have `req_dcommit`=1. Beat 7 has `req_last`=1 and `req_dcommit`=0. No other beat carries `req_first` or `req_last`.
- R6: While `req_valid`=1 and `req_ready`=0, every request output holds its value on the next cycle. The beat advances only on a cycle with `req_ready`=1.
- R7: `done` is high for exactly one cycle, the cycle after beat 7 is taken. `req_valid` is low in that cycle.
- R8: A command with `asi_restricted`=1 and `priv_mode`=0 and an aligned address faults with `fault_code`=1.
- R9: A command whose effective address has nonzero bits [5:0] faults with `fault_code`=2, even if the privilege fault also applies. Code 0 means no fault and never appears with `fault_valid`.
- R10: A faulting command issues no request. `fault_valid` is high for one cycle, the cycle after acceptance, and `cmd_ready` is high again in that same cycle.
- R11: Faults are judged on the values present at acceptance. Changes to `priv_mode` or `asi_restricted` during beats have no effect on the beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken this cycle if valid |
| cmd_store | input | 1 | 1 = block store, 0 = block load |
| cmd_use_imm | input | 1 | 1 = immediate form, 0 = register form |
| cmd_base_a | input | ADDR_W | First base operand |
| cmd_base_b | input | ADDR_W | Second base operand (register form) |
| cmd_imm | input | IMM_W | Signed immediate offset (immediate form) |
| cmd_rd | input | REG_W | First register index of the group |
| priv_mode | input | 1 | Current level is privileged |
| asi_restricted | input | 1 | Access space needs privilege |
| req_valid | output | 1 | Beat request valid |
| req_ready | input | 1 | Memory takes the beat |
| req_addr | output | ADDR_W | Beat byte address |
| req_store | output | 1 | Beat direction |
| req_reg | output | REG_W | Register index moved by this beat |
| req_first | output | 1 | Beat is first of group |
| req_last | output | 1 | Beat is last of group |
| req_dcommit | output | 1 | Beat commit held until group retires |
| done | output | 1 | One-cycle pulse after the last beat is taken |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | 0 none, 1 privilege, 2 alignment |

## Verification
The properties do not require `req_ready` to stay low when `req_valid` is low. They also accept a `cmd_valid` that drops without being taken, so the memory side may raise ready at any time. They do assume that command fields are only meaningful in the cycle of acceptance. The stimulus therefore offers each command for a single cycle while `cmd_ready` is high, then drops it. During beats it toggles `req_ready` in an uneven pattern and swaps the privilege inputs to faulting values, which stay outside what the beats may depend on.

// File: rtl/blkmem_pkg.sv
package blkmem_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_PRIV  = 2'd1,
    FLT_ALIGN = 2'd2
  } flt_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;
endpackage

// File: rtl/blkmem_ea.sv
module blkmem_ea #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_sx;
  logic [ADDR_W-1:0] addend;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign imm_sx = imm[ADDR_W-1:0];
    end
  endgenerate

  assign addend = use_imm ? imm_sx : base_b;
  assign ea     = base_a + addend;
endmodule

// File: rtl/blkmem_fault.sv
module blkmem_fault
  import blkmem_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 6
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic              priv_mode,
  input  logic              asi_restricted,
  output flt_e              code
);
  // later checks overwrite earlier ones: alignment has top priority
  always_comb begin
    code = FLT_NONE;
    if (asi_restricted && !priv_mode) code = FLT_PRIV;
    if (|ea[ALIGN_BITS-1:0])          code = FLT_ALIGN;
  end
endmodule

// File: rtl/blkmem_tag.sv
module blkmem_tag #(
  parameter int BEATS = 8,
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] beat,
  output logic             first,
  output logic             last,
  output logic             dcommit
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

  generate
    if (BEATS == 1) begin : g_single
      assign first   = 1'b1;
      assign last    = 1'b1;
      assign dcommit = 1'b0;
    end else begin : g_multi
      assign first   = (beat == '0);
      assign last    = (beat == LAST_IDX);
      assign dcommit = !last;
    end
  endgenerate
endmodule

// File: rtl/blkmem_seq.sv
module blkmem_seq
  import blkmem_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IMM_W      = 13,
  parameter int REG_W      = 6,
  parameter int BEATS      = 8,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_store,
  input  logic              cmd_use_imm,
  input  logic [ADDR_W-1:0] cmd_base_a,
  input  logic [ADDR_W-1:0] cmd_base_b,
  input  logic [IMM_W-1:0]  cmd_imm,
  input  logic [REG_W-1:0]  cmd_rd,
  input  logic              priv_mode,
  input  logic              asi_restricted,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_store,
  output logic [REG_W-1:0]  req_reg,
  output logic              req_first,
  output logic              req_last,
  output logic              req_dcommit,
  output logic              done,
  output logic              fault_valid,
  output logic [1:0]        fault_code
);
  localparam int CNT_W      = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int BYTE_SH    = $clog2(BEAT_BYTES);
  localparam int ALIGN_BITS = $clog2(BEATS * BEAT_BYTES);

  st_e               st_q;
  logic [CNT_W-1:0]  beat_q;
  logic [ADDR_W-1:0] ea_q;
  logic [REG_W-1:0]  rd_q;
  logic              store_q;
  logic              done_q;
  logic              fv_q;
  flt_e              fc_q;

  logic [ADDR_W-1:0] ea_new;
  flt_e              flt_new;
  logic              accept;
  logic              take;

  blkmem_ea #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_ea (
    .base_a  (cmd_base_a),
    .base_b  (cmd_base_b),
    .imm     (cmd_imm),
    .use_imm (cmd_use_imm),
    .ea      (ea_new)
  );

  blkmem_fault #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_fault (
    .ea             (ea_new),
    .priv_mode      (priv_mode),
    .asi_restricted (asi_restricted),
    .code           (flt_new)
  );

  blkmem_tag #(.BEATS(BEATS), .CNT_W(CNT_W)) u_tag (
    .beat    (beat_q),
    .first   (req_first),
    .last    (req_last),
    .dcommit (req_dcommit)
  );

  assign cmd_ready = (st_q == ST_IDLE);
  assign req_valid = (st_q == ST_RUN);
  assign accept    = cmd_valid && cmd_ready;
  assign take      = req_valid && req_ready;

  assign req_addr  = ea_q + (ADDR_W'(beat_q) << BYTE_SH);
  assign req_reg   = rd_q + REG_W'(beat_q);
  assign req_store = store_q;

  assign done        = done_q;
  assign fault_valid = fv_q;
  assign fault_code  = fv_q ? fc_q : FLT_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      ea_q    <= '0;
      rd_q    <= '0;
      store_q <= 1'b0;
      done_q  <= 1'b0;
      fv_q    <= 1'b0;
      fc_q    <= FLT_NONE;
    end else begin
      done_q <= 1'b0;
      fv_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            ea_q    <= ea_new;
            rd_q    <= cmd_rd;
            store_q <= cmd_store;
            beat_q  <= '0;
            fc_q    <= flt_new;
            if (flt_new != FLT_NONE) begin
              fv_q <= 1'b1;
            end else begin
              st_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (take) begin
            if (req_last) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkmem_seq_chk.sv
module blkmem_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int REG_W      = 6,
  parameter int BEAT_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_store,
  input logic [REG_W-1:0]  req_reg,
  input logic              req_first,
  input logic              req_last,
  input logic              req_dcommit,
  input logic              done,
  input logic              fault_valid,
  input logic [1:0]        fault_code
);
  // R1
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cmd_ready);

  // R1
  accept_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (req_valid != fault_valid));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_last) |=>
      (req_valid && req_addr == $past(req_addr) + ADDR_W'(BEAT_BYTES)));

  // R4
  reg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_last) |=>
      (req_reg == $past(req_reg) + 1'b1 && req_store == $past(req_store)));

  // R5
  tag_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_last != req_dcommit));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_addr) && $stable(req_reg) &&
       $stable(req_store) && $stable(req_first) && $stable(req_last)));

  // R7
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_last) |=> (done && !req_valid));

  // R9
  code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (fault_code == 2'd1 || fault_code == 2'd2));

  // R10
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (!req_valid && cmd_ready));

  // R10
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);
endmodule

bind blkmem_seq blkmem_seq_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .BEAT_BYTES(BEAT_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_store(req_store), .req_reg(req_reg), .req_first(req_first),
  .req_last(req_last), .req_dcommit(req_dcommit), .done(done),
  .fault_valid(fault_valid), .fault_code(fault_code)
);

// File: tb/test_blkmem_seq.sv
`timescale 1ns/1ps
module test_blkmem_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_store = 1'b0;
  logic        cmd_use_imm = 1'b0;
  logic [31:0] cmd_base_a = '0;
  logic [31:0] cmd_base_b = '0;
  logic [12:0] cmd_imm = '0;
  logic [5:0]  cmd_rd = '0;
  logic        priv_mode = 1'b1;
  logic        asi_restricted = 1'b0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic        req_store;
  logic [5:0]  req_reg;
  logic        req_first, req_last, req_dcommit;
  logic        done, fault_valid;
  logic [1:0]  fault_code;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  blkmem_seq i_blkmem_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_store(cmd_store), .cmd_use_imm(cmd_use_imm), .cmd_base_a(cmd_base_a),
    .cmd_base_b(cmd_base_b), .cmd_imm(cmd_imm), .cmd_rd(cmd_rd),
    .priv_mode(priv_mode), .asi_restricted(asi_restricted),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_store(req_store), .req_reg(req_reg), .req_first(req_first),
    .req_last(req_last), .req_dcommit(req_dcommit), .done(done),
    .fault_valid(fault_valid), .fault_code(fault_code)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input bit st, input bit ui, input logic [31:0] a,
                         input logic [31:0] b, input logic [12:0] im,
                         input logic [5:0] rd, input bit pv, input bit rs);
    logic [31:0] ea;
    logic [1:0]  ef;
    logic [31:0] prev;
    string       areq;
    string       freq;
    int          n;
    int          guard;
    bit          rdy;
    ea = ui ? a + {{19{im[12]}}, im} : a + b;
    ef = 2'd0;
    if (rs && !pv) ef = 2'd1;
    if (ea[5:0] != 6'd0) ef = 2'd2;
    areq = ui ? "R3" : "R2";
    freq = (ef == 2'd2) ? "R9" : "R8";
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "cmd_ready before command", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_store = st; cmd_use_imm = ui; cmd_base_a = a;
    cmd_base_b = b; cmd_imm = im; cmd_rd = rd; priv_mode = pv; asi_restricted = rs;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_base_b = 32'hDEAD_BEEF;
    if (ef != 2'd0) begin
      chk(fault_valid == 1'b1, "R10", "fault pulse", fault_valid, 1);
      chk(fault_code == ef, freq, "fault code", fault_code, ef);
      chk(req_valid == 1'b0, "R10", "no request on fault", req_valid, 0);
      chk(cmd_ready == 1'b1, "R10", "ready during fault pulse", cmd_ready, 1);
      @(negedge clk);
      chk(fault_valid == 1'b0, "R10", "fault pulse width", fault_valid, 0);
      chk(req_valid == 1'b0, "R10", "still no request", req_valid, 0);
    end else begin
      chk(fault_valid == 1'b0, "R11", "no fault", fault_valid, 0);
      priv_mode = 1'b0; asi_restricted = 1'b1; // R11: ignored during beats
      n = 0; guard = 0; prev = '0; rdy = 1'b1;
      while (n < 8 && guard < 200) begin
        if (!rdy) chk(req_addr == prev, "R6", "held address", req_addr, prev);
        chk(req_valid == 1'b1, "R1", "beat valid", req_valid, 1);
        chk(cmd_ready == 1'b0, "R1", "busy not ready", cmd_ready, 0);
        chk(fault_valid == 1'b0, "R11", "no fault on later beat", fault_valid, 0);
        chk(req_addr == ea + 32'(8 * n), areq, "beat address", req_addr, ea + 32'(8 * n));
        chk(req_reg == rd + 6'(n), "R4", "beat register", req_reg, rd + 6'(n));
        chk(req_store == st, "R4", "beat direction", req_store, st);
        chk(req_first == (n == 0), "R5", "first tag", req_first, (n == 0));
        chk(req_last == (n == 7), "R5", "last tag", req_last, (n == 7));
        chk(req_dcommit == (n != 7), "R5", "delayed-commit tag", req_dcommit, (n != 7));
        prev = req_addr;
        rdy = (cyc % 3) != 1;
        cyc++;
        req_ready = rdy;
        @(negedge clk);
        req_ready = 1'b0;
        if (rdy) n++;
        guard++;
      end
      chk(done == 1'b1, "R7", "done after last beat", done, 1);
      chk(req_valid == 1'b0, "R7", "no request with done", req_valid, 0);
      @(negedge clk);
      chk(done == 1'b0, "R7", "done width", done, 0);
      priv_mode = 1'b1; asi_restricted = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "reset ready", cmd_ready, 1);
    chk(req_valid == 1'b0, "R1", "reset no request", req_valid, 0);
    chk(done == 1'b0, "R7", "reset done", done, 0);
    chk(fault_valid == 1'b0, "R10", "reset fault", fault_valid, 0);

    // R9 R8: sweep every low-address offset with every privilege pair
    for (int lo = 0; lo < 64; lo++) begin
      for (int pr = 0; pr < 4; pr++) begin
        run_cmd(lo[0], 1'b0, 32'h0000_1000 + 32'(lo), 32'h0000_0040,
                13'd0, 6'(lo), pr[0], pr[1]);
      end
    end

    // R3: immediate form, positive and negative offsets, base_b ignored
    for (int k = 0; k < 8; k++) begin
      logic [12:0] im;
      case (k)
        0: im = 13'd0;
        1: im = 13'd64;
        2: im = -13'sd64;
        3: im = 13'h0FC0;
        4: im = 13'h1000;
        5: im = 13'd8;
        6: im = -13'sd4;
        default: im = 13'h1FC0;
      endcase
      run_cmd(k[0], 1'b1, 32'h0001_0000, 32'h0000_0123, im, 6'd8 * 6'(k), 1'b1, 1'b1);
    end

    // R2 R4: address wrap and register index wrap
    run_cmd(1'b1, 1'b0, 32'hFFFF_FFC0, 32'h0000_0040, 13'd0, 6'd60, 1'b0, 1'b0);
    run_cmd(1'b0, 1'b0, 32'hFFFF_FF80, 32'h0000_0000, 13'd0, 6'd63, 1'b1, 1'b0);
    for (int r = 56; r < 64; r++) begin
      run_cmd(r[0], 1'b1, 32'h0000_2000, 32'h0, 13'h1F80, 6'(r), 1'b1, 1'b1);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule